// File: doc/BRIEF.md
# Receive Descriptor Ring DMA Writer

This block takes received Ethernet frame bytes from a byte stream that marks the first and last byte of each frame and stores them in shared memory. Storage is organised as a ring of two-word descriptors: the first word holds a word-aligned buffer address with two control flags in its two low bits, the second word holds status. Each descriptor names one 128-byte buffer. A frame longer than one buffer continues into the next descriptors of the ring.

The engine reads and writes memory through a single word-wide request port with one-cycle read latency. After filling a buffer it writes the status word, then hands the buffer to software by setting the ownership flag in the address word. At the end of each frame it pulses a receive-complete event and sets a sticky flag. If the next buffer is still owned by software, the frame is dropped and a sticky no-buffer flag is set. Software gives buffers back by clearing their ownership flag, and clears either sticky flag by pulsing its clear input.

Top module: `rxring_dma_writer`

## Requirements
- R1: Frame bytes are packed little-endian into 32-bit words (byte k of a word in bits 8k+7..8k). They are written to the buffer at byte address {addr_word[31:2], 2'b00}, which holds 128 bytes. The 129th byte of a frame goes to the buffer of the next descriptor. Every memory access is word aligned.
- R2: After a descriptor whose address word has bit 1 (wrap) set, the next descriptor is at `ring_base`. Otherwise the next descriptor is 8 bytes further on. Bits 31:1 of the address word are written back unchanged.
- R3: After filling a buffer, the engine first writes its status word (descriptor offset 4) and then its address word with bit 0 (owned) set. It never writes into a buffer whose owned bit it read as 1. If a frame meets such a descriptor, the rest of the frame is dropped and no complete event is raised.
- R4: In the status word, bit 14 (start of frame) is 1 only for the first buffer of a frame.
- R5: In the status word, bits 11:0 (length) are zero for every buffer but the last, and bit 15 (end of frame) is 0 for those buffers. The last buffer holds the total frame length in bytes and has bit 15 set.
- R6: Each completed frame gives a one-cycle pulse on `irq_rx_done` and sets `sts_frame_rcvd`. The flag stays set until a cycle with `clr_frame_rcvd` high clears it, and a new completion wins over a clear.
- R7: Meeting an owned descriptor at the start of a frame or within a frame sets `sts_no_buf`. The flag stays set until `clr_no_buf` clears it. After a drop, the engine stays on the same descriptor.
- R8: While `rx_en` is low, `in_ready` and `mem_req` are low the following cycle. After re-enabling, the first descriptor used is the one at `ring_base`.
- R9: Bytes that arrive outside a frame without the start marker are discarded and written nowhere.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Receive enable; low holds the engine idle at the ring base |
| ring_base | input | 32 | Byte address of descriptor 0 |
| in_valid | input | 1 | Stream byte valid |
| in_data | input | 8 | Stream byte |
| in_sof | input | 1 | Byte is the first of a frame |
| in_eof | input | 1 | Byte is the last of a frame |
| in_ready | output | 1 | Engine accepts a byte this cycle |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Word-aligned byte address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read request |
| irq_rx_done | output | 1 | One-cycle pulse per completed frame |
| sts_frame_rcvd | output | 1 | Sticky frame-received flag |
| sts_no_buf | output | 1 | Sticky buffer-not-available flag |
| clr_frame_rcvd | input | 1 | Clears sts_frame_rcvd |
| clr_no_buf | input | 1 | Clears sts_no_buf |

## Verification
A wrong descriptor index shows up in memory as soon as the next frame ends: the status and owned bit land on the wrong descriptor, and one frame later a wrap error puts the next frame outside the ring. A wrong byte position inside the buffer corrupts the packed words of the frame that is being written. A wrong start, end or length flag is visible in the status word of the same frame. A stale ownership decision shows as a no-buffer flag or as an overwritten sentinel word within one frame time. A sweep over every frame length from 1 to 260 bytes walks the ring many times and crosses each buffer boundary at every position.

// File: rtl/rxring_dma_writer.sv
module rxring_dma_writer #(
  parameter int BUF_BYTES = 128,
  parameter int LEN_W     = 12,
  parameter int SOF_BIT   = 14,
  parameter int EOF_BIT   = 15
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_en,
  input  logic [31:0] ring_base,
  input  logic        in_valid,
  input  logic [7:0]  in_data,
  input  logic        in_sof,
  input  logic        in_eof,
  output logic        in_ready,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic [31:0] mem_rdata,
  output logic        irq_rx_done,
  output logic        sts_frame_rcvd,
  output logic        sts_no_buf,
  input  logic        clr_frame_rcvd,
  input  logic        clr_no_buf
);
  localparam int POS_W = $clog2(BUF_BYTES) + 1;

  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_CHECK, S_FILL, S_POLL, S_DROP, S_STAT, S_OWN} state_t;

  state_t           state;
  logic [31:0]      desc_addr, addr_word, wbuf, wr_data, stat_word;
  logic [POS_W-1:0] pos;
  logic [LEN_W-1:0] flen;
  logic             first_buf, last_flag, in_frame, irq_q, done_q, nobuf_q;
  logic [1:0]       lane;
  logic             acc, take, data_we;

  assign in_ready = (state == S_FILL) || (state == S_POLL) || (state == S_DROP);
  assign acc      = in_valid && in_ready;
  assign take     = acc && (state == S_FILL) && (in_frame || in_sof);
  assign lane     = pos[1:0];
  assign data_we  = take && (lane == 2'd3 || in_eof);

  always_comb begin
    wr_data = '0;
    for (int k = 0; k < 4; k++) begin
      if (2'(k) < lane)       wr_data[8*k +: 8] = wbuf[8*k +: 8];
      else if (2'(k) == lane) wr_data[8*k +: 8] = in_data;
    end
  end

  assign stat_word = (last_flag ? 32'(flen) : 32'd0)
                   | (32'(first_buf) << SOF_BIT)
                   | (32'(last_flag) << EOF_BIT);

  assign mem_req = (state == S_FETCH) || data_we || (state == S_STAT) || (state == S_OWN);
  assign mem_we  = mem_req && (state != S_FETCH);

  always_comb begin
    case (state)
      S_FILL:  mem_addr = {addr_word[31:2], 2'b00} + 32'({pos[POS_W-2:2], 2'b00});
      S_STAT:  mem_addr = desc_addr + 32'd4;
      default: mem_addr = desc_addr;
    endcase
    case (state)
      S_FILL:  mem_wdata = wr_data;
      S_STAT:  mem_wdata = stat_word;
      S_OWN:   mem_wdata = addr_word | 32'd1;
      default: mem_wdata = '0;
    endcase
  end

  assign irq_rx_done    = irq_q;
  assign sts_frame_rcvd = done_q;
  assign sts_no_buf     = nobuf_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      desc_addr <= '0;
      addr_word <= '0;
      wbuf      <= '0;
      pos       <= '0;
      flen      <= '0;
      first_buf <= 1'b0;
      last_flag <= 1'b0;
      in_frame  <= 1'b0;
      irq_q     <= 1'b0;
      done_q    <= 1'b0;
      nobuf_q   <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      if (clr_frame_rcvd) done_q  <= 1'b0;
      if (clr_no_buf)     nobuf_q <= 1'b0;
      if (!rx_en) begin
        state     <= S_IDLE;
        desc_addr <= ring_base;
        pos       <= '0;
        in_frame  <= 1'b0;
        first_buf <= 1'b0;
        last_flag <= 1'b0;
      end else begin
        case (state)
          S_IDLE:  state <= S_FETCH;
          S_FETCH: state <= S_CHECK;
          S_CHECK: begin
            addr_word <= mem_rdata;
            pos       <= '0;
            if (!mem_rdata[0])  state <= S_FILL;
            else if (in_frame) begin
              nobuf_q <= 1'b1;
              state   <= S_DROP;
            end else            state <= S_POLL;
          end
          S_POLL: begin
            if (in_valid) begin
              if (in_sof) nobuf_q <= 1'b1;
              state <= in_eof ? S_FETCH : S_DROP;
            end else state <= S_FETCH;
          end
          S_DROP: begin
            if (acc && in_eof) begin
              in_frame <= 1'b0;
              state    <= S_FETCH;
            end
          end
          S_FILL: begin
            if (take) begin
              wbuf[8*lane +: 8] <= in_data;
              pos      <= pos + 1'b1;
              in_frame <= 1'b1;
              flen     <= in_frame ? flen + 1'b1 : LEN_W'(1);
              if (!in_frame) first_buf <= 1'b1;
              if (in_eof) begin
                last_flag <= 1'b1;
                state     <= S_STAT;
              end else if (pos == POS_W'(BUF_BYTES - 1)) state <= S_STAT;
            end
          end
          S_STAT: state <= S_OWN;
          S_OWN: begin
            desc_addr <= addr_word[1] ? ring_base : desc_addr + 32'd8;
            first_buf <= 1'b0;
            pos       <= '0;
            if (last_flag) begin
              irq_q     <= 1'b1;
              done_q    <= 1'b1;
              last_flag <= 1'b0;
              in_frame  <= 1'b0;
            end
            state <= S_FETCH;
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/rxring_dma_writer_chk.sv
module rxring_dma_writer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        rx_en,
  input logic [31:0] ring_base,
  input logic        in_valid,
  input logic [7:0]  in_data,
  input logic        in_sof,
  input logic        in_eof,
  input logic        in_ready,
  input logic        mem_req,
  input logic        mem_we,
  input logic [31:0] mem_addr,
  input logic [31:0] mem_wdata,
  input logic [31:0] mem_rdata,
  input logic        irq_rx_done,
  input logic        sts_frame_rcvd,
  input logic        sts_no_buf,
  input logic        clr_frame_rcvd,
  input logic        clr_no_buf
);
  AST_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n) mem_req |-> mem_addr[1:0] == 2'b00); // R1
  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) irq_rx_done |=> !irq_rx_done); // R6
  AST_IRQ_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n) irq_rx_done |-> sts_frame_rcvd); // R6
  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) clr_frame_rcvd |=> (!sts_frame_rcvd || irq_rx_done)); // R6
  AST_NOBUF_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (sts_no_buf && !clr_no_buf) |=> sts_no_buf); // R7
  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !rx_en |=> (!in_ready && !mem_req)); // R8
endmodule

bind rxring_dma_writer rxring_dma_writer_chk chk_i (.*);

// File: tb/rxring_dma_writer_tb_top.sv
module rxring_dma_writer_tb_top;
  localparam logic [31:0] RING = 32'h100;
  localparam logic [31:0] BUFB = 32'h1000;

  logic clk = 1'b0, rst_n = 1'b0, rx_en = 1'b0;
  logic [31:0] ring_base = RING;
  logic in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
  logic [7:0] in_data = '0;
  logic in_ready, mem_req, mem_we, irq_rx_done, sts_frame_rcvd, sts_no_buf;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic clr_frame_rcvd = 1'b0, clr_no_buf = 1'b0;

  logic [31:0] mem [0:4095];
  logic tb_we = 1'b0;
  logic [11:0] tb_idx = '0;
  logic [31:0] tb_val = '0;

  int checks = 0, errors = 0, irq_cnt = 0, exp_irq = 0, cur = 0, cycles = 0;

  always #10 clk = ~clk;

  rxring_dma_writer dut_i (.*);

  always @(posedge clk) begin
    if (tb_we) mem[tb_idx] <= tb_val;
    if (mem_req) begin
      if (mem_we) mem[mem_addr[13:2]] <= mem_wdata;
      else        mem_rdata <= mem[mem_addr[13:2]];
    end
  end

  always @(negedge clk) if (rst_n && irq_rx_done) irq_cnt++;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog expired act=%0d exp<150000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic logic [31:0] bufa(int i);
    return BUFB + 32'(i * 128);
  endfunction

  function automatic logic [7:0] pat(int seed, int i);
    return 8'((seed * 31 + i * 7 + 3) & 255);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr_word(input int idx, input logic [31:0] val);
    @(negedge clk);
    tb_we = 1'b1; tb_idx = 12'(idx); tb_val = val;
    @(negedge clk);
    tb_we = 1'b0;
  endtask

  task automatic init_ring(input logic [3:0] owned);
    for (int i = 0; i < 4; i++) begin
      wr_word(int'(RING >> 2) + 2 * i, bufa(i) | (i == 3 ? 32'd2 : 32'd0) | 32'(owned[i]));
      wr_word(int'(RING >> 2) + 2 * i + 1, 32'd0);
    end
    repeat (6) @(negedge clk);
  endtask

  task automatic push(input logic [7:0] b, input logic s, input logic e);
    @(negedge clk);
    in_valid = 1'b1; in_data = b; in_sof = s; in_eof = e;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    #1;
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
  endtask

  task automatic send_frame(input int len, input int seed, input bit with_sof);
    for (int i = 0; i < len; i++) push(pat(seed, i), with_sof && i == 0, i == len - 1);
    repeat (8) @(negedge clk);
  endtask

  task automatic check_frame(input int len, input int seed, input int first);
    int nb, bad;
    nb = (len + 127) / 128;
    for (int b = 0; b < nb; b++) begin
      int idx;
      logic [31:0] w0, w1, e0, e1;
      idx = (first + b) % 4;
      w0 = mem[int'(RING >> 2) + 2 * idx];
      w1 = mem[int'(RING >> 2) + 2 * idx + 1];
      e0 = bufa(idx) | (idx == 3 ? 32'd2 : 32'd0) | 32'd1;
      e1 = (b == 0 ? 32'h4000 : 32'd0) | (b == nb - 1 ? (32'h8000 | 32'(len)) : 32'd0);
      chk(w0 == e0, "R3 R2 address word", w0, e0);
      chk(w1 == e1, "R4 R5 status word", w1, e1);
    end
    bad = 0;
    for (int j = 0; j < len; j++) begin
      logic [31:0] a;
      logic [7:0] got;
      a = bufa((first + j / 128) % 4) + 32'(j % 128);
      got = mem[a[13:2]][8 * a[1:0] +: 8];
      if (got !== pat(seed, j)) bad++;
    end
    chk(bad == 0, "R1 buffer data", 32'(bad), 32'd0);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) begin
      mem[int'(RING >> 2) + 2 * i]     = bufa(i) | (i == 3 ? 32'd2 : 32'd0);
      mem[int'(RING >> 2) + 2 * i + 1] = 32'd0;
    end
    repeat (3) @(negedge clk);
    chk(!in_ready && !mem_req, "R8 reset idle", {30'd0, in_ready, mem_req}, 32'd0);
    chk(!irq_rx_done && !sts_frame_rcvd && !sts_no_buf, "R6 R7 reset flags",
        {29'd0, irq_rx_done, sts_frame_rcvd, sts_no_buf}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    rx_en = 1'b1;
    repeat (4) @(negedge clk);

    // R1 R4 R5 R6: single-buffer frame
    send_frame(10, 1, 1'b1);
    check_frame(10, 1, 0);
    exp_irq++;
    chk(irq_cnt == exp_irq, "R6 irq count", 32'(irq_cnt), 32'(exp_irq));
    chk(sts_frame_rcvd, "R6 sticky set", 32'(sts_frame_rcvd), 32'd1);
    @(negedge clk); clr_frame_rcvd = 1'b1; @(negedge clk); clr_frame_rcvd = 1'b0;
    chk(!sts_frame_rcvd, "R6 sticky cleared", 32'(sts_frame_rcvd), 32'd0);
    cur = 1;

    // R1 R2 R5: chained frame over three buffers up to the wrap descriptor
    send_frame(300, 2, 1'b1);
    check_frame(300, 2, cur);
    exp_irq++;
    chk(irq_cnt == exp_irq, "R6 irq count chained", 32'(irq_cnt), 32'(exp_irq));
    cur = 0;

    // R3 R7: descriptor 0 still owned, frame dropped
    wr_word(int'(bufa(0) >> 2), 32'hA5A5_5A5A);
    send_frame(20, 3, 1'b1);
    chk(sts_no_buf, "R7 no-buffer flag", 32'(sts_no_buf), 32'd1);
    chk(irq_cnt == exp_irq, "R3 no complete on drop", 32'(irq_cnt), 32'(exp_irq));
    chk(mem[bufa(0) >> 2] == 32'hA5A5_5A5A, "R3 owned buffer untouched", mem[bufa(0) >> 2], 32'hA5A5_5A5A);
    @(negedge clk); clr_no_buf = 1'b1; @(negedge clk); clr_no_buf = 1'b0;
    chk(!sts_no_buf, "R7 flag cleared", 32'(sts_no_buf), 32'd0);

    // R1 R5: exactly one full buffer, then next descriptor
    init_ring(4'b0000);
    send_frame(128, 4, 1'b1);
    check_frame(128, 4, cur);
    send_frame(5, 5, 1'b1);
    check_frame(5, 5, 1);
    exp_irq += 2;
    cur = 2;

    // R9: fragment without start marker is discarded
    init_ring(4'b0000);
    send_frame(6, 6, 1'b0);
    chk(irq_cnt == exp_irq, "R9 fragment no complete", 32'(irq_cnt), 32'(exp_irq));
    send_frame(9, 7, 1'b1);
    check_frame(9, 7, cur);
    exp_irq++;
    chk(irq_cnt == exp_irq, "R9 next frame lands", 32'(irq_cnt), 32'(exp_irq));
    cur = 3;

    // R3 R4 R7: next buffer owned in mid frame
    init_ring(4'b0111);
    send_frame(200, 8, 1'b1);
    begin
      logic [31:0] w0, w1;
      w0 = mem[int'(RING >> 2) + 6];
      w1 = mem[int'(RING >> 2) + 7];
      chk(w0 == (bufa(3) | 32'd3), "R3 first buffer handed over", w0, bufa(3) | 32'd3);
      chk(w1 == 32'h4000, "R4 R5 partial frame status", w1, 32'h4000);
    end
    chk(sts_no_buf, "R7 mid-frame no buffer", 32'(sts_no_buf), 32'd1);
    chk(irq_cnt == exp_irq, "R3 no complete for cut frame", 32'(irq_cnt), 32'(exp_irq));
    @(negedge clk); clr_no_buf = 1'b1; @(negedge clk); clr_no_buf = 1'b0;
    cur = 0;

    // R8: disable and re-enable restarts at the ring base
    init_ring(4'b0000);
    send_frame(3, 9, 1'b1);
    check_frame(3, 9, 0);
    exp_irq++;
    rx_en = 1'b0;
    repeat (2) @(negedge clk);
    chk(!in_ready && !mem_req, "R8 idle while disabled", {30'd0, in_ready, mem_req}, 32'd0);
    rx_en = 1'b1;
    init_ring(4'b0000);
    send_frame(4, 10, 1'b1);
    check_frame(4, 10, 0);
    exp_irq++;
    chk(irq_cnt == exp_irq, "R8 irq after re-enable", 32'(irq_cnt), 32'(exp_irq));
    cur = 1;

    // R1 R2 R4 R5 R6: sweep every length from 1 to 260
    for (int len = 1; len <= 260; len++) begin
      init_ring(4'b0000);
      send_frame(len, len + 20, 1'b1);
      check_frame(len, len + 20, cur);
      exp_irq++;
      chk(irq_cnt == exp_irq, "R6 sweep irq", 32'(irq_cnt), 32'(exp_irq));
      cur = (cur + (len + 127) / 128) % 4;
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule